// File: doc/BRIEF.md
# Reloadable Local Timer with Interrupt Steering

This block is a free-running down-counter with a programmable 28-bit reload value. Software reaches it through a single-cycle write strobe with a two-bit word address and a combinational read port. When the count runs out, the block sets a pending flag and starts the next period from the reload value. A three-bit destination code steers that pending event to exactly one of eight interrupt lines: a normal or a fast request line of one of four cores.

Software sets the reload value, the run bit and the interrupt-enable bit in the control word, and picks the destination in the routing word. Each interrupt is acknowledged through the command word. Writing 1 to one bit there drops the flag. Writing 1 to another bit restarts the count from the reload value at once. The control word reads back the pending flag. Word addresses: 0 = routing, 1 = control/status, 2 = command (reads as zero), 3 = unused (reads as zero).

Top module: `lt_route_timer`

## Requirements
- R1: After a synchronous reset, the routing word and the control word both read 0 (timer stopped, interrupt disabled, reload value 0, flag clear), and all eight interrupt lines are low.
- R2: In the control word (address 1), bits 27:0 are the reload value, bit 28 is run and bit 29 is interrupt enable. All three read back as written. Bit 30 always reads 0. Bit 31 reads the pending flag, and writing it has no effect on the flag.
- R3: The routing word (address 0) stores written bits 2:0. Bits 31:3 always read 0.
- R4: While run is 1, the count drops by one every clock. A clock edge that finds the count at 0 sets the pending flag and loads the reload value. The period is therefore reload+1 cycles. While run is 0, the count holds and no expiry occurs.
- R5: Writing a word with bit 31 set to the command word (address 2) clears the pending flag.
- R6: Writing a word with bit 30 set to the command word loads the count from the reload value. On that edge the load takes precedence over counting, so no expiry happens.
- R7: Writing 0 to the command word changes neither the pending flag nor the count.
- R8: When a clear command and an expiry fall on the same clock edge, the pending flag stays set.
- R9: Destination codes 0..3 drive the normal request line of core 0..3 (irq_o[code]). Codes 4..7 drive the fast request line of core 0..3 (fiq_o[code-4]). Every other line stays low.
- R10: An interrupt line is high only while the pending flag is 1 and interrupt enable is 1. Clearing interrupt enable drops the line but keeps the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 2 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| irq_o | output | 4 | Normal interrupt request, one per core |
| fiq_o | output | 4 | Fast interrupt request, one per core |

## Verification
The assertions assume that the write strobe and address settle away from the clock edge and are never X after reset, and that one write touches one word per cycle. The bench drives every write on a falling edge and holds it for exactly one cycle. The assertions on the counter and on the flag also assume the command and run inputs are stable between edges. Same-edge collisions between a command and an expiry are set up deliberately, by counting cycles from a known expiry rather than by random timing.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int DATA_W   = 32;
    localparam int RELOAD_W = 28;
    localparam int N_CORES  = 4;
    localparam int ADDR_W   = 2;
    localparam int CODE_W   = $clog2(N_CORES) + 1;

    localparam int RUN_BIT  = 28;
    localparam int IEN_BIT  = 29;
    localparam int PEND_BIT = 31;
    localparam int DROP_BIT = 31;
    localparam int LOAD_BIT = 30;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_ROUTE = 2'd0,
        ADDR_CTRL  = 2'd1,
        ADDR_CMD   = 2'd2,
        ADDR_SPARE = 2'd3
    } addr_e;

    typedef struct packed {
        logic                ien;
        logic                run;
        logic [RELOAD_W-1:0] reload;
    } ctrl_t;

    typedef struct packed {
        logic drop;
        logic load;
    } cmd_t;

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.ien    = w[IEN_BIT];
        c.run    = w[RUN_BIT];
        c.reload = w[RELOAD_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c, input logic pend);
        logic [DATA_W-1:0] w;
        w                 = '0;
        w[RELOAD_W-1:0]   = c.reload;
        w[RUN_BIT]        = c.run;
        w[IEN_BIT]        = c.ien;
        w[PEND_BIT]       = pend;
        return w;
    endfunction

    function automatic cmd_t cmd_unpack(input logic wr, input logic [DATA_W-1:0] w);
        cmd_t c;
        c.drop = wr & w[DROP_BIT];
        c.load = wr & w[LOAD_BIT];
        return c;
    endfunction

endpackage

// File: rtl/lt_counter.sv
module lt_counter #(
    parameter int W = lt_pkg::RELOAD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] reload_val,
    output logic         expire
);

    logic [W-1:0] cnt_q;
    logic         at_zero;

    assign at_zero = (cnt_q == '0);
    assign expire  = run && !load && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload_val;
        end else if (run) begin
            if (at_zero) cnt_q <= reload_val;
            else         cnt_q <= cnt_q - 1'b1;
        end
    end

    // R4: a running count that is not at zero steps down by one
    a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
        (run && !load && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R4: a stopped count holds its value
    a_r4_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt_q));

    // R6: a forced load takes the reload value
    a_r6_forced_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(reload_val)));

endmodule

// File: rtl/lt_pending.sv
module lt_pending (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic drop,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst)       pend <= 1'b0;
        else if (set)  pend <= 1'b1;
        else if (drop) pend <= 1'b0;
    end

    // R4, R8: an expiry always leaves the flag set, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> pend);

    // R5: a clear without a competing expiry empties the flag
    a_r5_drop: assert property (@(posedge clk) disable iff (rst)
        (drop && !set) |=> !pend);

    // R7: with neither event the flag keeps its value
    a_r7_idle_keeps: assert property (@(posedge clk) disable iff (rst)
        (!drop && !set) |=> $stable(pend));

    // R1: the flag is clear after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> !pend);

endmodule

// File: rtl/lt_router.sv
module lt_router #(
    parameter int N      = lt_pkg::N_CORES,
    localparam int CW    = $clog2(N) + 1
) (
    input  logic          pend,
    input  logic          ien,
    input  logic [CW-1:0] code,
    output logic [N-1:0]  irq,
    output logic [N-1:0]  fiq
);

    logic active;
    assign active = pend && ien;

    for (genvar i = 0; i < N; i++) begin : g_core
        assign irq[i] = active && (code == CW'(i));
        assign fiq[i] = active && (code == CW'(N + i));
    end

endmodule

// File: rtl/lt_route_timer.sv
module lt_route_timer #(
    parameter int N_CORES = lt_pkg::N_CORES
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_wr,
    input  logic [lt_pkg::ADDR_W-1:0] bus_addr,
    input  logic [lt_pkg::DATA_W-1:0] bus_wdata,
    output logic [lt_pkg::DATA_W-1:0] bus_rdata,
    output logic [N_CORES-1:0]        irq_o,
    output logic [N_CORES-1:0]        fiq_o
);

    import lt_pkg::*;

    localparam int CW = $clog2(N_CORES) + 1;

    addr_e           addr;
    ctrl_t           ctrl_q;
    logic [CW-1:0]   route_q;
    cmd_t            cmd;
    logic            expire;
    logic            pend;

    assign addr = addr_e'(bus_addr);
    assign cmd  = cmd_unpack(bus_wr && (addr == ADDR_CMD), bus_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            route_q <= '0;
        end else if (bus_wr) begin
            case (addr)
                ADDR_ROUTE: route_q <= bus_wdata[CW-1:0];
                ADDR_CTRL:  ctrl_q  <= ctrl_unpack(bus_wdata);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADDR_ROUTE: bus_rdata = DATA_W'(route_q);
            ADDR_CTRL:  bus_rdata = ctrl_pack(ctrl_q, pend);
            default:    bus_rdata = '0;
        endcase
    end

    lt_counter #(.W(RELOAD_W)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .run        (ctrl_q.run),
        .load       (cmd.load),
        .reload_val (ctrl_q.reload),
        .expire     (expire)
    );

    lt_pending u_pending (
        .clk  (clk),
        .rst  (rst),
        .set  (expire),
        .drop (cmd.drop),
        .pend (pend)
    );

    lt_router #(.N(N_CORES)) u_router (
        .pend (pend),
        .ien  (ctrl_q.ien),
        .code (route_q),
        .irq  (irq_o),
        .fiq  (fiq_o)
    );

    // R9: never more than one destination line at a time
    a_r9_single_line: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fiq_o, irq_o}));

    // R10: no line is high unless the flag is pending and enabled
    a_r10_gated: assert property (@(posedge clk) disable iff (rst)
        !(pend && ctrl_q.ien) |-> ({fiq_o, irq_o} == '0));

    // R10: a pending, enabled flag always reaches some line
    a_r10_delivered: assert property (@(posedge clk) disable iff (rst)
        (pend && ctrl_q.ien) |-> ($countones({fiq_o, irq_o}) == 1));

    // R6: a forced load on an edge that would expire suppresses the expiry
    a_r6_no_expire_on_load: assert property (@(posedge clk) disable iff (rst)
        cmd.load |-> !expire);

endmodule

// File: tb/lt_route_timer_bench.sv
module lt_route_timer_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;
    logic [3:0]  fiq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [1:0] A_ROUTE = 2'd0;
    localparam logic [1:0] A_CTRL  = 2'd1;
    localparam logic [1:0] A_CMD   = 2'd2;
    localparam logic [1:0] A_SPARE = 2'd3;

    // {route code, expected {fiq_o, irq_o}}
    localparam logic [10:0] VEC [8] = '{
        {3'd6, 8'h40}, {3'd1, 8'h02}, {3'd4, 8'h10}, {3'd3, 8'h08},
        {3'd0, 8'h01}, {3'd7, 8'h80}, {3'd2, 8'h04}, {3'd5, 8'h20}
    };

    always #5 clk = ~clk;

    lt_route_timer u_lt_route_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_pend(output int n);
        logic [31:0] w;
        n = -1;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            rd(A_CTRL, w);
            if (w[31]) begin
                n = k;
                break;
            end
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        int n;
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        idle(3);
        rst = 1'b0;

        // R1 reset state
        check("R1 lines", {24'h0, fiq_o, irq_o}, 32'h0);
        rd(A_ROUTE, w); check("R1 route", w, 32'h0);
        rd(A_CTRL, w);  check("R1 ctrl", w, 32'h0);

        // R3 routing width
        wr(A_ROUTE, 32'hFFFF_FFFF);
        rd(A_ROUTE, w); check("R3 route upper bits zero", w, 32'h7);
        rd(A_SPARE, w); check("R3 spare word zero", w, 32'h0);

        // R2 control fields, bit 30 zero, bit 31 not writable
        wr(A_CTRL, 32'hC000_0ABC);
        rd(A_CTRL, w); check("R2 ctrl readback, 31:30 ignored", w, 32'h0000_0ABC);
        wr(A_CTRL, 32'h2FFF_FFFF);
        rd(A_CTRL, w); check("R2 ctrl ien and max reload", w, 32'h2FFF_FFFF);
        rd(A_CMD, w);  check("R2 command word reads zero", w, 32'h0);

        // R4 start with count 0: first running edge expires
        wr(A_ROUTE, 32'h0);
        wr(A_CTRL, 32'h3000_03E8);
        rd(A_CTRL, w); check("R4 not yet pending", w, 32'h3000_03E8);
        @(negedge clk);
        rd(A_CTRL, w); check("R4 pending after first running edge", w, 32'hB000_03E8);

        // R9 routing vector walk
        for (int i = 0; i < 8; i++) begin
            wr(A_ROUTE, {29'h0, VEC[i][10:8]});
            check($sformatf("R9 code %0d", VEC[i][10:8]), {24'h0, fiq_o, irq_o},
                  {24'h0, VEC[i][7:0]});
        end

        // R10 interrupt enable gating (route is now 5)
        wr(A_CTRL, 32'h1000_03E8);
        check("R10 lines low with ien=0", {24'h0, fiq_o, irq_o}, 32'h0);
        rd(A_CTRL, w); check("R10 flag kept with ien=0", w, 32'h9000_03E8);
        wr(A_CTRL, 32'h3000_03E8);
        check("R10 line back with ien=1", {24'h0, fiq_o, irq_o}, 32'h20);

        // R7 writing zero to the command word
        wr(A_CMD, 32'h0);
        rd(A_CTRL, w); check("R7 zero command keeps flag", w[31], 32'h1);

        // R5 clear
        wr(A_CMD, 32'h8000_0000);
        rd(A_CTRL, w); check("R5 flag cleared", w[31], 32'h0);
        check("R5 lines low", {24'h0, fiq_o, irq_o}, 32'h0);

        // R4 period = reload + 1
        wr(A_CTRL, 32'h2000_0005);
        wr(A_CMD, 32'hC000_0000);
        wr(A_CTRL, 32'h3000_0005);
        wait_pend(n);
        check("R4 period after forced load", n, 6);
        check("R9 fiq core1 on expiry", {24'h0, fiq_o, irq_o}, 32'h20);

        // R8 clear on the edge of the next expiry (6 edges after the last)
        idle(5);
        wr(A_CMD, 32'h8000_0000);
        rd(A_CTRL, w); check("R8 expiry beats clear", w[31], 32'h1);
        wr(A_CMD, 32'h8000_0000);
        rd(A_CTRL, w); check("R5 clear after collision", w[31], 32'h0);
        wait_pend(n);
        check("R4 steady period", n, 5);

        // R6 forced load on an expiry edge suppresses it
        wr(A_CMD, 32'h8000_0000);
        idle(4);
        wr(A_CMD, 32'h4000_0000);
        rd(A_CTRL, w); check("R6 load beats expiry", w[31], 32'h0);
        wait_pend(n);
        check("R6 full period after load", n, 6);

        // R4 stopped count holds
        wr(A_CTRL, 32'h2000_0005);
        wr(A_CMD, 32'h8000_0000);
        idle(30);
        rd(A_CTRL, w); check("R4 no expiry while stopped", w[31], 32'h0);
        wr(A_CTRL, 32'h3000_0005);
        wait_pend(n);
        check("R4 held count resumes", n, 5);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule